// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Rotator

This block computes the cosine and sine of a first-quadrant angle by CORDIC rotation, one micro-rotation per clock cycle on a single shared datapath. The caller supplies a 16-bit unsigned target angle, where 16'h4000 is 45 degrees and 16'h8000 is 90 degrees. It also supplies the starting vector, already scaled down by the CORDIC gain: X = 16'h136D (about 0.607) and Y = 0 in Q3.13. After fifteen rotations the block returns cosine on `cos_out`, sine on `sin_out` and the accumulated rotation angle on `angle_out`.

The angle accumulator runs one step ahead of the vector. It is loaded with the 45-degree table entry while the vector takes its first, fixed anticlockwise rotation at shift 0. On every busy cycle the accumulator is compared with the target, and that comparison picks the direction of the next vector rotation. The request side is a valid/ready pair. `start_ready` is high exactly when the block is idle, and a request is taken on a rising clock edge with `start_valid` and `start_ready` both high. While a run is in progress `start_ready` is low, so requests are back-pressured and have no effect. The result side has no back-pressure. `done` pulses for one cycle and the registered results then stay put until the next accepted request or reset.

Top module: `cordic_rotator`

## Requirements
- R1: While and right after synchronous reset: `start_ready`=1, `busy`=0, `done`=0, `cos_out`=0, `sin_out`=0 and `angle_out`=17'h04000.
- R2: A request is accepted on a rising edge where `start_valid` and `start_ready` are both 1. `busy` is 1 from that edge until `done` rises, and `start_ready` is the inverse of `busy`.
- R3: `done` is a one-cycle pulse, first visible after the 15th rising edge following the accepting edge. `busy` falls on that same edge.
- R4: A request presented while `busy` is 1 is ignored. The running computation and its results are unchanged.
- R5: On acceptance the angle accumulator is loaded with 16'h4000 (45 degrees), X and Y take `x_init` and `y_init`, and the first vector rotation uses shift 0, anticlockwise.
- R6: Each busy step n (1 to 14) compares the accumulator Z with the target. If Z <= target (ties included), it adds atan(2^-n) to Z and marks the next rotation anticlockwise. Otherwise it subtracts and marks it clockwise. The 16-bit table values for n=0..14 are 4000, 25C8, 13F6, 0A22, 0516, 028C, 0146, 00A3, 0051, 0029, 0014, 000A, 0005, 0003, 0001 (hex).
- R7: Rotation i (0 to 14) uses arithmetic right shifts by i. Anticlockwise: X' = X - (Y>>>i), Y' = Y + (X>>>i). Clockwise: X' = X + (Y>>>i), Y' = Y - (X>>>i). The arithmetic wraps in 16 bits.
- R8: When idle and no request is accepted, `cos_out`, `sin_out` and `angle_out` keep their values from cycle to cycle.
- R9: With the prescaled start vector, `cos_out` and `sin_out` lie within 16 LSB (Q3.13) of the true cosine and sine for any target from 16'h0000 to 16'h8000.
- R10: `angle_out` is a 17-bit two's-complement accumulator on the same angle scale, so a run that dips below zero does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Request valid |
| start_ready | output | 1 | Block idle and able to take a request |
| target_angle | input | 16 | Target angle, 16'h4000 = 45 degrees, range 0..16'h8000 |
| x_init | input | 16 | Starting X, signed Q3.13 |
| y_init | input | 16 | Starting Y, signed Q3.13 |
| busy | output | 1 | Rotation in progress |
| done | output | 1 | One-cycle result pulse |
| cos_out | output | 16 | Final X, signed Q3.13 |
| sin_out | output | 16 | Final Y, signed Q3.13 |
| angle_out | output | 17 | Final accumulated angle, signed |

## Verification
The accepting edge starts the count. `busy` is due one edge later, and `done` with the final X, Y and Z is due after exactly the 15th edge that follows. The bench drives inputs at the falling edge and walks fifteen falling edges after acceptance. It requires `done` low at the first fourteen and high at the fifteenth, and compares the results only at that point. A few idle cycles later it compares them again, and it checks the reset values one falling edge after reset is applied. Results are compared bit-exactly with an integer model of the rotation and direction rules, and against a real-valued sine and cosine within the stated tolerance.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  localparam int ANG_W = 16;

  typedef enum logic {
    ROT_CW  = 1'b0,
    ROT_CCW = 1'b1
  } rot_dir_e;

  // arctan(2^-k) on the scale 16'h4000 = 45 degrees
  function automatic logic [ANG_W-1:0] atan_entry(input int unsigned k);
    case (k)
      0:  atan_entry = 16'h4000;
      1:  atan_entry = 16'h25C8;
      2:  atan_entry = 16'h13F6;
      3:  atan_entry = 16'h0A22;
      4:  atan_entry = 16'h0516;
      5:  atan_entry = 16'h028C;
      6:  atan_entry = 16'h0146;
      7:  atan_entry = 16'h00A3;
      8:  atan_entry = 16'h0051;
      9:  atan_entry = 16'h0029;
      10: atan_entry = 16'h0014;
      11: atan_entry = 16'h000A;
      12: atan_entry = 16'h0005;
      13: atan_entry = 16'h0003;
      14: atan_entry = 16'h0001;
      default: atan_entry = '0;
    endcase
  endfunction

endpackage

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER  = 15,
  parameter int IDX_W = $clog2(ITER)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_valid,
  output logic             start_ready,
  output logic             load,
  output logic             busy,
  output logic             step_en,
  output logic [IDX_W-1:0] idx,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ITER - 1);

  assign start_ready = !busy;
  assign load        = start_valid && start_ready;
  // the angle side looks one table step ahead, so it stops one rotation early
  assign step_en     = busy && (idx != LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]              idx,
  output logic [cordic_pkg::ANG_W-1:0]  atan_val
);

  always_comb begin
    atan_val = cordic_pkg::atan_entry(32'(idx));
  end

endmodule

// File: rtl/cordic_angle_unit.sv
module cordic_angle_unit #(
  parameter int IDX_W = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                load,
  input  logic                                step_en,
  input  logic [IDX_W-1:0]                    idx,
  input  logic [cordic_pkg::ANG_W-1:0]        target,
  output logic signed [cordic_pkg::ANG_W:0]   z_q,
  output cordic_pkg::rot_dir_e                dir_q
);

  import cordic_pkg::*;

  localparam logic signed [ANG_W:0] Z_START = {1'b0, atan_entry(0)};

  logic [ANG_W-1:0]        tgt_q;
  logic [IDX_W-1:0]        nidx;
  logic [ANG_W-1:0]        step_val;
  logic signed [ANG_W:0]   tgt_s;
  logic signed [ANG_W:0]   step_s;
  logic                    go_up;

  assign nidx   = idx + 1'b1;
  assign tgt_s  = $signed({1'b0, tgt_q});
  assign step_s = $signed({1'b0, step_val});
  assign go_up  = (z_q <= tgt_s);

  cordic_atan_rom #(.IDX_W(IDX_W)) u_rom (
    .idx      (nidx),
    .atan_val (step_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      z_q   <= Z_START;
      dir_q <= ROT_CCW;
      tgt_q <= '0;
    end else if (load) begin
      z_q   <= Z_START;
      dir_q <= ROT_CCW;
      tgt_q <= target;
    end else if (step_en) begin
      if (go_up) begin
        z_q   <= z_q + step_s;
        dir_q <= ROT_CCW;
      end else begin
        z_q   <= z_q - step_s;
        dir_q <= ROT_CW;
      end
    end
  end

endmodule

// File: rtl/cordic_xy_unit.sv
module cordic_xy_unit #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      rot_en,
  input  logic signed [DATA_W-1:0]  x_init,
  input  logic signed [DATA_W-1:0]  y_init,
  input  logic [IDX_W-1:0]          idx,
  input  cordic_pkg::rot_dir_e      dir,
  output logic signed [DATA_W-1:0]  x_q,
  output logic signed [DATA_W-1:0]  y_q
);

  import cordic_pkg::*;

  logic signed [DATA_W-1:0] x_sh, y_sh, x_nx, y_nx;

  always_comb begin
    x_sh = x_q >>> idx;
    y_sh = y_q >>> idx;
    if (dir == ROT_CCW) begin
      x_nx = x_q - y_sh;
      y_nx = y_q + x_sh;
    end else begin
      x_nx = x_q + y_sh;
      y_nx = y_q - x_sh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= x_init;
      y_q <= y_init;
    end else if (rot_en) begin
      x_q <= x_nx;
      y_q <= y_nx;
    end
  end

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
  parameter int DATA_W = 16,
  parameter int ITER   = 15
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_valid,
  output logic                              start_ready,
  input  logic [cordic_pkg::ANG_W-1:0]      target_angle,
  input  logic signed [DATA_W-1:0]          x_init,
  input  logic signed [DATA_W-1:0]          y_init,
  output logic                              busy,
  output logic                              done,
  output logic signed [DATA_W-1:0]          cos_out,
  output logic signed [DATA_W-1:0]          sin_out,
  output logic signed [cordic_pkg::ANG_W:0] angle_out
);

  localparam int IDX_W = (ITER > 1) ? $clog2(ITER) : 1;

  logic                 load, step_en;
  logic [IDX_W-1:0]     idx;
  cordic_pkg::rot_dir_e dir;

  cordic_ctrl #(.ITER(ITER), .IDX_W(IDX_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .load        (load),
    .busy        (busy),
    .step_en     (step_en),
    .idx         (idx),
    .done        (done)
  );

  cordic_angle_unit #(.IDX_W(IDX_W)) u_angle (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step_en (step_en),
    .idx     (idx),
    .target  (target_angle),
    .z_q     (angle_out),
    .dir_q   (dir)
  );

  cordic_xy_unit #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_xy (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .rot_en (busy),
    .x_init (x_init),
    .y_init (y_init),
    .idx    (idx),
    .dir    (dir),
    .x_q    (cos_out),
    .y_q    (sin_out)
  );

endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
  parameter int DATA_W = 16,
  parameter int ITER   = 15
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              start_valid,
  input logic                              start_ready,
  input logic                              busy,
  input logic                              done,
  input logic signed [DATA_W-1:0]          cos_out,
  input logic signed [DATA_W-1:0]          sin_out,
  input logic signed [cordic_pkg::ANG_W:0] angle_out
);

  logic [7:0] run_cnt;
  logic       accept;

  assign accept = start_valid && start_ready;

  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (accept) run_cnt <= '0;
    else if (busy)   run_cnt <= run_cnt + 1'b1;
  end

  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_done_ends_run: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == 8'(ITER)));

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (busy && start_valid) |-> !start_ready);

  a_r5_angle_load: assert property (@(posedge clk) disable iff (rst)
    accept |=> (angle_out == 17'sh04000));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> ($stable(cos_out) && $stable(sin_out) && $stable(angle_out)));

endmodule

bind cordic_rotator cordic_rotator_chk #(.DATA_W(DATA_W), .ITER(ITER)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .busy        (busy),
  .done        (done),
  .cos_out     (cos_out),
  .sin_out     (sin_out),
  .angle_out   (angle_out)
);

// File: tb/cordic_rotator_tb.sv
`timescale 1ns/1ps
module cordic_rotator_tb;

  localparam int NVEC = 9;
  localparam int TOL  = 16;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h2AAB, 16'h4000, 16'h5555, 16'h0000, 16'h8000,
    16'h1234, 16'h6E3F, 16'h0800, 16'h7A10
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               start_valid = 1'b0;
  logic               start_ready;
  logic [15:0]        target_angle = '0;
  logic signed [15:0] x_init = 16'sh136D;
  logic signed [15:0] y_init = 16'sh0000;
  logic               busy, done;
  logic signed [15:0] cos_out, sin_out;
  logic signed [16:0] angle_out;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cordic_rotator u_dut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .target_angle(target_angle), .x_init(x_init), .y_init(y_init),
    .busy(busy), .done(done), .cos_out(cos_out), .sin_out(sin_out),
    .angle_out(angle_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tbl(input int k);
    int v [15] = '{16384, 9672, 5110, 2594, 1302, 652, 326, 163, 81, 41, 20, 10, 5, 3, 1};
    return v[k];
  endfunction

  // integer model built from R5, R6, R7
  task automatic model(input int tgt, output int xo, output int yo, output int zo);
    logic signed [15:0] x, y, xn, yn;
    int z;
    bit ccw;
    x = 16'sh136D; y = 16'sh0000; z = tbl(0); ccw = 1'b1;
    for (int k = 0; k < 15; k++) begin
      if (ccw) begin xn = x - (y >>> k); yn = y + (x >>> k); end
      else     begin xn = x + (y >>> k); yn = y - (x >>> k); end
      x = xn; y = yn;
      if (k < 14) begin
        if (z <= tgt) begin z = z + tbl(k + 1); ccw = 1'b1; end
        else          begin z = z - tbl(k + 1); ccw = 1'b0; end
      end
    end
    xo = int'(x); yo = int'(y); zo = z;
  endtask

  task automatic run(input logic [15:0] tgt, input bit poke);
    int  ex, ey, ez, hc, hs, ha;
    bit  early = 1'b0;
    real th;
    @(negedge clk);
    target_angle = tgt;
    start_valid  = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    check(busy && !start_ready, "R2 busy after accept", int'(busy), 1);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (poke && k == 6) start_valid = 1'b0;
      if (k < 15 && done) early = 1'b1;
      if (poke && k == 5) begin
        check(!start_ready, "R4 ready low while busy", int'(start_ready), 0);
        target_angle = 16'h0800;
        start_valid  = 1'b1;
      end
    end
    check(!early, "R3 no early done", int'(early), 0);
    check(done && !busy, "R3 done at 15th edge", int'(done), 1);
    model(int'(tgt), ex, ey, ez);
    check(int'(cos_out) == ex, "R7 cos exact", int'(cos_out), ex);
    check(int'(sin_out) == ey, "R7 sin exact", int'(sin_out), ey);
    check(int'(angle_out) == ez, "R6 R10 angle exact", int'(angle_out), ez);
    th = real'(tgt) * 3.14159265358979 / 65536.0;
    ex = int'($cos(th) * 8192.0);
    ey = int'($sin(th) * 8192.0);
    check((int'(cos_out) - ex) <= TOL && (ex - int'(cos_out)) <= TOL,
          "R9 cos accuracy", int'(cos_out), ex);
    check((int'(sin_out) - ey) <= TOL && (ey - int'(sin_out)) <= TOL,
          "R9 sin accuracy", int'(sin_out), ey);
    hc = int'(cos_out); hs = int'(sin_out); ha = int'(angle_out);
    repeat (3) @(negedge clk);
    check(!done, "R3 done one cycle", int'(done), 0);
    check(int'(cos_out) == hc && int'(sin_out) == hs && int'(angle_out) == ha,
          "R8 results held", int'(cos_out), hc);
  endtask

  task automatic check_reset_state();
    check(start_ready && !busy && !done, "R1 idle flags", int'(busy), 0);
    check(cos_out == 0 && sin_out == 0, "R1 xy cleared", int'(cos_out), 0);
    check(angle_out == 17'sh04000, "R1 R5 angle start", int'(angle_out), 16384);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NVEC; i++) run(VEC[i], 1'b0);

    // R4: mid-run request must not disturb the 30-degree result
    run(16'h2AAB, 1'b1);

    // R5: one cycle after acceptance the angle sits at 45 degrees
    @(negedge clk);
    target_angle = 16'h1000;
    start_valid  = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    check(angle_out == 17'sh04000 && cos_out == 16'sh136D && sin_out == 0,
          "R5 load values", int'(angle_out), 16384);

    // R1: reset during a run
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule